// File: doc/BRIEF.md
# Physical Memory Access Guard

This block decides whether a single physical memory access may proceed. Every cycle it takes an address, a byte count, the kind of access (instruction fetch, data load or data store), the current privilege level and the full set of protection entries. Each entry is one configuration byte plus one address word. The verdict comes out one clock later as registered outputs.

The verdict has four parts: grant or deny, whether a protection entry was responsible, that entry's index, and the base-2 logarithm of a region size. An upstream translation cache uses the region size to shrink a cached mapping when the deciding region does not fill a whole page. The entry tables are held elsewhere and reach this block as flat vectors.

Three kinds of region are supported: a range bounded by the previous entry's address, a small aligned block sized by the granularity parameter, and a power-of-two aligned block. Entries are scanned from index 0 upward, and the first one that grants the access decides the result.

Top module: `memguard`

## Requirements
- R1: Configuration bits [4:3] select the region kind: 0 = disabled, 1 = ranged, 2 = small block, 3 = power-of-two block. A disabled entry never takes part, not even in the machine-mode bypass of R7.
- R2: A ranged entry i covers the bytes from `areg[i-1]*4` (0 for entry 0) up to `areg[i]*4 - 1`. It covers nothing when `areg[i]*4` is not above the start.
- R3: A small-block entry covers `2^(G+2)` bytes starting at `areg*4`, where G is the granularity parameter.
- R4: A power-of-two entry whose address word ends in k one-bits covers `2^(k+3)` bytes. The block starts at `areg*4` with the low k+3 byte-address bits cleared.
- R5: An entry admits an access only when every byte from `addr` to `addr+size-1` lies inside its region (a size of 0 counts as 1) and the entry's permission bit is set. A fetch (code 0) needs bit 2, a load (code 1) needs bit 0, and a store (code 2) needs bit 1.
- R6: The lowest-indexed entry that grants decides the result. `hit_o` is 1 and `hit_idx_o` carries that entry's index.
- R7: At privilege 3 (machine), the first enabled entry that is not locked grants, whatever the address and permissions. An entry counts as locked if its own bit 7 is set, or if the next entry is ranged and has bit 7 set.
- R8: When no entry grants, `hit_o` is 0 and `grant_o` is 1 only at privilege 3. Privileges 0 and 1 are denied.
- R9: `span_lg_o` equals PAGE_BITS when nothing hit, or when both the start and the end+1 of the deciding region are multiples of the page size. Otherwise it is the smallest n with `2^n >= end - start` (0 for an empty ranged region).
- R10: Results appear one clock after the inputs. During reset the outputs read grant 0, hit 0, index 0 and span PAGE_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | PA_W | Physical byte address of the access |
| size_i | input | SZ_W | Access length in bytes |
| acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| cfg_i | input | N_ENT*8 | Configuration byte of each entry, entry i at bits [8i+7:8i] |
| areg_i | input | N_ENT*(PA_W-2) | Address word of each entry, entry i in slice i |
| grant_o | output | 1 | Access allowed |
| hit_o | output | 1 | An entry decided the result |
| hit_idx_o | output | clog2(N_ENT) | Index of the deciding entry |
| span_lg_o | output | clog2(PA_W+2) | Log2 of the region size for the translation cache |

## Verification
The machine-mode bypass and the ordinary address-and-permission match can both succeed in the same cycle on different entries, so the priority scan has to pick the lower index. The bench provokes this on purpose. In one case a lower entry is unlocked but lacks the permission, and a higher entry covers the address with the right permission. In another case locking a ranged successor quietly locks its predecessor. Randomised tables run at all three privilege levels, and a bench model that walks the entries one at a time judges the index and span of every access.

// File: rtl/memguard_pkg.sv
package memguard_pkg;

  typedef enum logic [1:0] {
    MG_OFF   = 2'd0,
    MG_TOR   = 2'd1,
    MG_NA4   = 2'd2,
    MG_NAPOT = 2'd3
  } mg_mode_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } mg_acc_e;

  localparam logic [1:0] PRIV_MACH = 2'd3;

  localparam int BIT_R    = 0;
  localparam int BIT_W    = 1;
  localparam int BIT_X    = 2;
  localparam int BIT_LOCK = 7;

  // smallest n with 2^n >= d (0 for d <= 1)
  function automatic logic [6:0] ceil_lg64(input logic [63:0] d);
    logic [6:0] n;
    n = 7'd64;
    for (int k = 63; k >= 0; k--) begin
      if ((64'd1 << k) >= d) n = 7'(k);
    end
    return n;
  endfunction

endpackage

// File: rtl/memguard_entry.sv
module memguard_entry
  import memguard_pkg::*;
#(
  parameter int PA_W = 34,
  parameter int G    = 0
) (
  input  logic [7:0]        cfg_i,
  input  logic [PA_W-3:0]   areg_i,
  input  logic [PA_W-3:0]   prev_areg_i,
  input  logic              next_tor_lock_i,
  input  logic [PA_W:0]     addr_x_i,
  input  logic [PA_W:0]     last_i,
  input  logic [1:0]        acc_i,
  input  logic              machine_i,
  output logic              hit_o,
  output logic [PA_W:0]     sa_o,
  output logic [PA_W:0]     ea_o,
  output logic              empty_o
);
  localparam int RW = PA_W - 2;
  localparam int EW = PA_W + 1;
  localparam logic [EW-1:0] NA_LEN = EW'(1) << (G + 2);

  function automatic logic [RW-1:0] ones_mask(input logic [RW-1:0] a);
    return a ^ (a + RW'(1));
  endfunction

  function automatic logic [EW-1:0] word_to_byte(input logic [RW-1:0] a);
    return {1'b0, a, 2'b00};
  endfunction

  mg_mode_e        mode_w;
  logic [RW-1:0]   nap_m_w;
  logic            perm_w;
  logic            eff_lock_w;
  logic            inside_w;
  logic            spare_unused;

  assign mode_w       = mg_mode_e'(cfg_i[4:3]);
  assign nap_m_w      = ones_mask(areg_i);
  assign spare_unused = ^cfg_i[6:5];

  always_comb begin
    sa_o    = '0;
    ea_o    = '0;
    empty_o = 1'b1;
    unique case (mode_w)
      MG_TOR: begin
        sa_o    = word_to_byte(prev_areg_i);
        ea_o    = word_to_byte(areg_i) - EW'(1);
        empty_o = word_to_byte(areg_i) <= word_to_byte(prev_areg_i);
      end
      MG_NA4: begin
        sa_o    = word_to_byte(areg_i);
        ea_o    = word_to_byte(areg_i) + NA_LEN - EW'(1);
        empty_o = 1'b0;
      end
      MG_NAPOT: begin
        sa_o    = word_to_byte(areg_i & ~nap_m_w);
        ea_o    = {1'b0, areg_i | nap_m_w, 2'b11};
        empty_o = 1'b0;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (mg_acc_e'(acc_i))
      ACC_FETCH: perm_w = cfg_i[BIT_X];
      ACC_LOAD:  perm_w = cfg_i[BIT_R];
      ACC_STORE: perm_w = cfg_i[BIT_W];
      default:   perm_w = 1'b0;
    endcase
  end

  assign eff_lock_w = cfg_i[BIT_LOCK] | next_tor_lock_i;
  assign inside_w   = !empty_o && (addr_x_i >= sa_o) && (last_i <= ea_o);
  assign hit_o      = (mode_w != MG_OFF) &&
                      ((machine_i && !eff_lock_w) || (inside_w && perm_w));

endmodule

// File: rtl/memguard_pick.sv
module memguard_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/memguard_span.sv
module memguard_span
  import memguard_pkg::*;
#(
  parameter int EW        = 35,
  parameter int PAGE_BITS = 12,
  parameter int LW        = 6
) (
  input  logic [EW-1:0] sa_i,
  input  logic [EW-1:0] ea_i,
  input  logic          empty_i,
  output logic [LW-1:0] lg_o
);
  logic [EW-1:0] ea_p1_w;
  logic [EW-1:0] diff_w;
  logic          aligned_w;

  assign ea_p1_w   = ea_i + EW'(1);
  assign aligned_w = (sa_i[PAGE_BITS-1:0] == '0) && (ea_p1_w[PAGE_BITS-1:0] == '0);
  assign diff_w    = empty_i ? '0 : (ea_i - sa_i);
  assign lg_o      = aligned_w ? LW'(PAGE_BITS) : LW'(ceil_lg64(64'(diff_w)));
endmodule

// File: rtl/memguard.sv
module memguard
  import memguard_pkg::*;
#(
  parameter int N_ENT     = 4,
  parameter int PA_W      = 34,
  parameter int G         = 0,
  parameter int PAGE_BITS = 12,
  parameter int SZ_W      = 4,
  localparam int RW = PA_W - 2,
  localparam int EW = PA_W + 1,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int LW = $clog2(EW + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PA_W-1:0]       addr_i,
  input  logic [SZ_W-1:0]       size_i,
  input  logic [1:0]            acc_i,
  input  logic [1:0]            priv_i,
  input  logic [N_ENT*8-1:0]    cfg_i,
  input  logic [N_ENT*RW-1:0]   areg_i,
  output logic                  grant_o,
  output logic                  hit_o,
  output logic [IW-1:0]         hit_idx_o,
  output logic [LW-1:0]         span_lg_o
);
  logic [EW-1:0]   addr_x_w;
  logic [EW-1:0]   last_w;
  logic [SZ_W-1:0] size_m1_w;
  logic            machine_w;
  logic [N_ENT-1:0] hit_vec_w;
  logic [EW-1:0]   sa_w    [N_ENT];
  logic [EW-1:0]   ea_w    [N_ENT];
  logic [N_ENT-1:0] empty_w;
  logic            sel_any_w;
  logic [IW-1:0]   sel_idx_w;
  logic [EW-1:0]   sel_sa_w;
  logic [EW-1:0]   sel_ea_w;
  logic            sel_empty_w;
  logic [LW-1:0]   region_lg_w;
  logic [LW-1:0]   span_w;
  logic            grant_w;

  assign machine_w = (priv_i == PRIV_MACH);
  assign size_m1_w = (size_i == '0) ? '0 : size_i - SZ_W'(1);
  assign addr_x_w  = {1'b0, addr_i};
  assign last_w    = addr_x_w + EW'(size_m1_w);

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic [RW-1:0] prev_w;
    logic          nxt_lock_w;
    if (i == 0) begin : g_first
      assign prev_w = '0;
    end else begin : g_rest
      assign prev_w = areg_i[(i-1)*RW +: RW];
    end
    if (i == N_ENT - 1) begin : g_last
      assign nxt_lock_w = 1'b0;
    end else begin : g_mid
      assign nxt_lock_w = (cfg_i[(i+1)*8+3 +: 2] == 2'(MG_TOR)) && cfg_i[(i+1)*8+BIT_LOCK];
    end
    memguard_entry #(.PA_W(PA_W), .G(G)) u_ent (
      .cfg_i           (cfg_i[i*8 +: 8]),
      .areg_i          (areg_i[i*RW +: RW]),
      .prev_areg_i     (prev_w),
      .next_tor_lock_i (nxt_lock_w),
      .addr_x_i        (addr_x_w),
      .last_i          (last_w),
      .acc_i           (acc_i),
      .machine_i       (machine_w),
      .hit_o           (hit_vec_w[i]),
      .sa_o            (sa_w[i]),
      .ea_o            (ea_w[i]),
      .empty_o         (empty_w[i])
    );
  end

  memguard_pick #(.N(N_ENT), .IW(IW)) u_pick (
    .req_i (hit_vec_w),
    .any_o (sel_any_w),
    .idx_o (sel_idx_w)
  );

  always_comb begin
    sel_sa_w    = '0;
    sel_ea_w    = '0;
    sel_empty_w = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (IW'(i) == sel_idx_w) begin
        sel_sa_w    = sa_w[i];
        sel_ea_w    = ea_w[i];
        sel_empty_w = empty_w[i];
      end
    end
  end

  memguard_span #(.EW(EW), .PAGE_BITS(PAGE_BITS), .LW(LW)) u_span (
    .sa_i    (sel_sa_w),
    .ea_i    (sel_ea_w),
    .empty_i (sel_empty_w),
    .lg_o    (region_lg_w)
  );

  assign span_w  = sel_any_w ? region_lg_w : LW'(PAGE_BITS);
  assign grant_w = sel_any_w | machine_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o   <= 1'b0;
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
      span_lg_o <= LW'(PAGE_BITS);
    end else begin
      grant_o   <= grant_w;
      hit_o     <= sel_any_w;
      hit_idx_o <= sel_idx_w;
      span_lg_o <= span_w;
    end
  end

endmodule

// File: rtl/memguard_chk.sv
module memguard_chk
  import memguard_pkg::*;
#(
  parameter int N_ENT     = 4,
  parameter int PAGE_BITS = 12,
  parameter int IW        = 2,
  parameter int LW        = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       priv_i,
  input logic [N_ENT-1:0] hit_vec_w,
  input logic             grant_o,
  input logic             hit_o,
  input logic [IW-1:0]    hit_idx_o,
  input logic [LW-1:0]    span_lg_o
);
  // R6
  hit_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_vec_w) |=> hit_o);

  // R8
  miss_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|hit_vec_w) |=> !hit_o);

  // R8
  low_priv_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|hit_vec_w) && priv_i != PRIV_MACH) |=> !grant_o);

  // R6
  hit_grants_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> grant_o);

  // R9
  miss_page_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|hit_vec_w) |=> span_lg_o == LW'(PAGE_BITS));

  for (genvar i = 0; i < N_ENT; i++) begin : g_first
    localparam logic [N_ENT-1:0] LOWER = (N_ENT'(1) << i) - N_ENT'(1);
    // R6
    lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_vec_w[i] && !(|(hit_vec_w & LOWER))) |=> hit_idx_o == IW'(i));
  end
endmodule

bind memguard memguard_chk #(
  .N_ENT(N_ENT), .PAGE_BITS(PAGE_BITS), .IW(IW), .LW(LW)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .priv_i    (priv_i),
  .hit_vec_w (hit_vec_w),
  .grant_o   (grant_o),
  .hit_o     (hit_o),
  .hit_idx_o (hit_idx_o),
  .span_lg_o (span_lg_o)
);

// File: tb/memguard_tb_top.sv
`timescale 1ns/1ps
module memguard_tb_top;
  localparam int N  = 4;
  localparam int PA = 34;
  localparam int G  = 1;
  localparam int PB = 12;
  localparam int RW = PA - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [PA-1:0]     addr;
  logic [3:0]        size;
  logic [1:0]        acc;
  logic [1:0]        priv;
  logic [N*8-1:0]    cfg_flat;
  logic [N*RW-1:0]   ar_flat;
  logic              grant_o, hit_o;
  logic [1:0]        hit_idx_o;
  logic [5:0]        span_lg_o;

  logic [7:0]    cfg_t [N];
  logic [RW-1:0] ar_t  [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_flat[i*8 +: 8]  = cfg_t[i];
      ar_flat[i*RW +: RW] = ar_t[i];
    end
  end

  memguard #(.N_ENT(N), .PA_W(PA), .G(G), .PAGE_BITS(PB), .SZ_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .size_i(size), .acc_i(acc),
    .priv_i(priv), .cfg_i(cfg_flat), .areg_i(ar_flat), .grant_o(grant_o),
    .hit_o(hit_o), .hit_idx_o(hit_idx_o), .span_lg_o(span_lg_o)
  );

  int nchk = 0;
  int nbad = 0;

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  // ---- bench model: one entry at a time ----
  function automatic void region(input int i, output longint unsigned sa,
                                 output longint unsigned ea, output bit empty);
    longint unsigned base, top, sz;
    int k;
    sa = 0; ea = 0; empty = 1;
    case (cfg_t[i][4:3])
      2'd1: begin
        base  = (i == 0) ? 0 : longint'(ar_t[i-1]) * 4;
        top   = longint'(ar_t[i]) * 4;
        sa    = base; ea = top - 1; empty = (top <= base);
      end
      2'd2: begin
        sa = longint'(ar_t[i]) * 4; ea = sa + (64'd1 << (G + 2)) - 1; empty = 0;
      end
      2'd3: begin
        k = 0;
        while (k < RW && ar_t[i][k]) k++;
        sz = 64'd1 << (k + 3);
        sa = (longint'(ar_t[i]) * 4) & ~(sz - 1);
        ea = sa + sz - 1; empty = 0;
      end
      default: ;
    endcase
  endfunction

  function automatic void model(input longint unsigned a, input int sz, input int ac,
                                input int pv, output bit g, output bit h,
                                output int idx, output int lg);
    longint unsigned sa, ea, last, d;
    bit empty, lk, pm, in;
    g = (pv == 3); h = 0; idx = 0; lg = PB;
    last = a + ((sz == 0) ? 0 : sz - 1);
    for (int i = 0; i < N; i++) begin
      if (cfg_t[i][4:3] == 2'd0) continue;
      region(i, sa, ea, empty);
      lk = cfg_t[i][7] || (i + 1 < N && cfg_t[i+1][4:3] == 2'd1 && cfg_t[i+1][7]);
      pm = (ac == 0) ? cfg_t[i][2] : (ac == 1) ? cfg_t[i][0] : (ac == 2) ? cfg_t[i][1] : 1'b0;
      in = !empty && a >= sa && last <= ea;
      if ((pv == 3 && !lk) || (in && pm)) begin
        g = 1; h = 1; idx = i;
        if ((sa % (64'd1 << PB)) != 0 || ((ea + 1) % (64'd1 << PB)) != 0) begin
          d = empty ? 0 : ea - sa;
          lg = 0;
          while ((64'd1 << lg) < d) lg++;
        end
        return;
      end
    end
  endfunction

  task automatic clear_tab();
    for (int i = 0; i < N; i++) begin cfg_t[i] = 8'h00; ar_t[i] = '0; end
  endtask

  task automatic apply(input longint unsigned a, input int sz, input int ac, input int pv);
    @(negedge clk);
    addr = PA'(a); size = 4'(sz); acc = 2'(ac); priv = 2'(pv);
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input bit eg, input bit eh,
                            input int ei, input int el);
    nchk++;
    if (grant_o !== eg || hit_o !== eh || (eh && hit_idx_o !== 2'(ei)) ||
        span_lg_o !== 6'(el)) begin
      nbad++;
      $display("FAIL %s: actual g=%0b h=%0b idx=%0d span=%0d expected g=%0b h=%0b idx=%0d span=%0d",
               tag, grant_o, hit_o, hit_idx_o, span_lg_o, eg, eh, ei, el);
    end
  endtask

  task automatic chk(input string tag, input longint unsigned a, input int sz,
                     input int ac, input int pv, input bit eg, input bit eh,
                     input int ei, input int el);
    apply(a, sz, ac, pv);
    expect_out(tag, eg, eh, ei, el);
  endtask

  initial begin
    bit eg, eh;
    int ei, el;
    clear_tab();
    addr = '0; size = 4'd1; acc = 2'd1; priv = 2'd0;
    repeat (3) @(negedge clk);
    // R10 reset state
    expect_out("R10 reset", 0, 0, 0, PB);
    rst_n = 1'b1;

    // R8 empty table
    chk("R8 machine no entries", 'h10, 4, 1, 3, 1, 0, 0, PB);
    chk("R8 user no entries",    'h10, 4, 1, 0, 0, 0, 0, PB);

    // R2 ranged entry 0..0x3FF, read+write
    cfg_t[0] = 8'h0B; ar_t[0] = 'h100;
    chk("R2 ranged inside",      'h3FC, 4, 1, 0, 1, 1, 0, 10);
    chk("R5 straddles top",      'h3FC, 8, 1, 0, 0, 0, 0, PB);
    chk("R2 top exclusive",      'h400, 1, 1, 0, 0, 0, 0, PB);
    cfg_t[0] = 8'h09;
    chk("R5 store needs W",      'h10, 2, 2, 0, 0, 0, 0, PB);
    chk("R5 load with R",        'h10, 2, 1, 1, 1, 1, 0, 10);
    ar_t[0] = 'h400;
    chk("R9 page aligned range", 'h0, 4, 1, 0, 1, 1, 0, PB);

    // R3 small block, G=1 -> 8 bytes at 0x100, execute only
    cfg_t[0] = 8'h14; ar_t[0] = 'h40;
    chk("R3 block fetch",        'h104, 4, 0, 0, 1, 1, 0, 3);
    chk("R3 beyond block",       'h108, 4, 0, 0, 0, 0, 0, PB);
    chk("R5 size zero as one",   'h107, 0, 0, 0, 1, 1, 0, 3);
    chk("R5 load lacks R",       'h104, 4, 1, 0, 0, 0, 0, PB);

    // R4 power-of-two blocks
    cfg_t[0] = 8'h19; ar_t[0] = 'h3FF;
    chk("R4 8K block end",       'h1FF8, 8, 1, 1, 1, 1, 0, PB);
    chk("R4 past 8K block",      'h2000, 4, 1, 1, 0, 0, 0, PB);
    ar_t[0] = 'h3FE;
    chk("R4 8 byte block",       'hFF8, 8, 1, 0, 1, 1, 0, 3);
    chk("R4 below 8 byte block", 'hFF0, 4, 1, 0, 0, 0, 0, PB);
    ar_t[0] = '1;
    chk("R4 all ones whole space", 'h3_0000_0000, 8, 1, 0, 1, 1, 0, PB);

    // R6 priority
    clear_tab();
    cfg_t[0] = 8'h10; ar_t[0] = 'h40;
    cfg_t[1] = 8'h19; ar_t[1] = 'h3FF;
    chk("R6 lower lacks perm",   'h100, 4, 1, 0, 1, 1, 1, PB);
    cfg_t[0] = 8'h11;
    chk("R6 lower wins",         'h100, 4, 1, 0, 1, 1, 0, 3);
    chk("R6 machine bypass low", 'h100, 4, 2, 3, 1, 1, 0, 3);

    // R7 machine bypass and locking
    clear_tab();
    cfg_t[0] = 8'h08; ar_t[0] = 'h10;
    chk("R7 unlocked bypass",    'h5000, 4, 1, 3, 1, 1, 0, 6);
    chk("R8 user far address",   'h5000, 4, 1, 0, 0, 0, 0, PB);
    cfg_t[1] = 8'h88; ar_t[1] = 'h20;
    chk("R7 locked by successor", 'h5000, 4, 1, 3, 1, 0, 0, PB);
    cfg_t[1] = 8'h00; cfg_t[0] = 8'h88;
    chk("R7 own lock",           'h5000, 4, 1, 3, 1, 0, 0, PB);

    // R1 disabled entry skipped
    clear_tab();
    cfg_t[0] = 8'h07;
    chk("R1 off ignored machine", 'h0, 4, 1, 3, 1, 0, 0, PB);
    cfg_t[1] = 8'h11;
    chk("R1 off skipped",        'h0, 4, 1, 0, 1, 1, 1, 3);

    // random tables, all privilege levels
    void'($urandom(32'h5EED_0042));
    for (int t = 0; t < 300; t++) begin
      for (int i = 0; i < N; i++) begin
        cfg_t[i] = 8'(($urandom % 4) << 3) | 8'($urandom % 8);
        if ($urandom % 4 == 0) cfg_t[i][7] = 1'b1;
        ar_t[i] = RW'($urandom % 1100);
        if ($urandom % 4 == 0) ar_t[i] = ar_t[i] | RW'((32'd1 << ($urandom % 12)) - 1);
      end
      for (int n = 0; n < 16; n++) begin
        longint unsigned a;
        int sz, ac, pv;
        a  = $urandom % 4400;
        sz = 1 << ($urandom % 4);
        ac = $urandom % 3;
        pv = $urandom % 3;
        if (pv == 2) pv = 3;
        model(a, sz, ac, pv, eg, eh, ei, el);
        apply(a, sz, ac, pv);
        expect_out("R6 random vs model", eg, eh, ei, el);
      end
    end
    finish_run();
  end
endmodule